// File: doc/BRIEF.md
# TCP/UDP Port Priority Classifier

This block gives an IP packet a transmit priority and a drop-eligibility flag, chosen from the TCP/UDP port numbers carried in its header. An upstream parser presents the source and destination ports, a qualifier that says whether the packet is TCP or UDP over IP, and a one-cycle lookup strobe. One clock later the block reports whether any rule matched, with the 3-bit priority and drop bit of the winning rule.

Three kinds of rule are checked against both ports. The first is a fixed list of well-known port numbers (a build parameter), each with its own enable bit. The second is a set of programmable exact-match entries, each with its own enable bit. The third is one programmable window of ports with exclusive bounds. All table contents live in byte-wide registers behind a simple write/read port. Every 16-bit value is split into a low byte and a high byte, and the priority settings are packed two rules per byte.

Top module: `portPriClassifier`

## Requirements
- R1: After a synchronous reset every table byte reads 0x00 and `matchOut`, `priOut` and `dropOut` are 0.
- R2: Byte registers sit at these addresses: user entry i low byte at i and high byte at 8+i (i = 0..7); user enable at 16 (bit i = entry i); user priority pairs at 17..20; well-known enable at 21 (bit k = list entry k); well-known priority pairs at 22..25; range lower limit low/high at 26/27; range upper limit low/high at 28/29; range priority at 30. A write to any of these is read back unchanged on `rdData` from the clock after the write.
- R3: An enabled user entry whose 16-bit value equals the source or the destination port matches. Its settings come from the pair byte at 17 + i/2. An odd entry uses bits 7:5 as priority and bit 4 as drop. An even entry uses bits 3:1 as priority and bit 0 as drop.
- R4: A user entry whose enable bit is 0 never matches.
- R5: An enabled well-known list entry k matches when either port equals its listed number. Its settings come from byte 22 + k/2, with the same odd/even layout as R3. With its enable bit clear, it never matches.
- R6: The range matches a port only when the port is strictly greater than the lower limit and strictly less than the upper limit. Its priority is range-priority bits 3:1 and its drop flag is bit 0.
- R7: When the upper limit is less than or equal to the lower limit, the range matches nothing.
- R8: When several rules match, the winner is chosen in this order: well-known entries first (by list index, lowest first), then user entries in index order 0 to 7, then the range.
- R9: With no strobe, with the TCP/UDP qualifier low, or with no match, all three outputs are 0 in the following cycle.
- R10: Results appear on the clock edge after the strobe. A lookup strobed on the same edge as a table write still sees the old byte, and a lookup strobed on any later edge sees the new byte.
- R11: Reads from address 31 return 0x00, and writes to address 31 change no table byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Table byte write enable |
| wrAddr | input | 5 | Table byte write address |
| wrData | input | 8 | Table byte write data |
| rdAddr | input | 5 | Table byte read address |
| rdData | output | 8 | Read data for `rdAddr` (combinational) |
| lookupValid | input | 1 | Lookup strobe, one cycle per packet |
| isTcpUdp | input | 1 | Packet is TCP or UDP over IP |
| srcPort | input | 16 | TCP/UDP source port |
| dstPort | input | 16 | TCP/UDP destination port |
| matchOut | output | 1 | A rule matched (registered) |
| priOut | output | 3 | Priority of the winning rule (registered) |
| dropOut | output | 1 | Drop flag of the winning rule (registered) |

## Verification
The bench builds the block with its own well-known list instead of the default. In that list, entry 0 is port 80 and entry 7 is port 6000. Port 6000 is also programmed into a user entry, so one packet hits a well-known rule and a user rule together, and the precedence between the two kinds can be seen at the ports. The range bounds are set on both sides of user ports, which also puts the user-over-range order and the exclusive bounds within reach.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int PORT_W   = 16;
  localparam int PRI_W    = 3;
  localparam int N_USER   = 8;
  localparam int N_WK     = 8;
  // register map, derived from the entry counts
  localparam int A_USER_LO  = 0;
  localparam int A_USER_HI  = A_USER_LO + N_USER;
  localparam int A_USER_EN  = A_USER_HI + N_USER;
  localparam int A_USER_PRI = A_USER_EN + 1;
  localparam int A_WK_EN    = A_USER_PRI + N_USER / 2;
  localparam int A_WK_PRI   = A_WK_EN + 1;
  localparam int A_RLO_L    = A_WK_PRI + N_WK / 2;
  localparam int A_RLO_H    = A_RLO_L + 1;
  localparam int A_RHI_L    = A_RLO_L + 2;
  localparam int A_RHI_H    = A_RLO_L + 3;
  localparam int A_RNG_PRI  = A_RLO_L + 4;
  localparam int N_REGS     = A_RNG_PRI + 1;
  localparam int ADDR_W     = $clog2(N_REGS);
  localparam int N_SLOTS    = 2 ** ADDR_W;

  typedef struct packed {
    logic [N_REGS-1:0] wrByte;
    logic              classify;
  } ppcStrobe_t;
endpackage

// File: rtl/ppcCtrl.sv
module ppcCtrl
  import ppc_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              lookupValid,
  input  logic              isTcpUdp,
  output ppcStrobe_t        strobe
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_dec
    assign strobe.wrByte[i] = wrEn && (wrAddr == ADDR_W'(i));
  end
  assign strobe.classify = lookupValid && isTcpUdp;
endmodule

// File: rtl/ppcDatapath.sv
module ppcDatapath
  import ppc_pkg::*;
#(
  parameter logic [N_WK*PORT_W-1:0] WK_PORTS = {16'd110, 16'd23, 16'd21, 16'd25,
                                                16'd22, 16'd53, 16'd443, 16'd80}
) (
  input  logic              clk,
  input  logic              rst,
  input  ppcStrobe_t        strobe,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic [PORT_W-1:0] srcPort,
  input  logic [PORT_W-1:0] dstPort,
  output logic              matchOut,
  output logic [PRI_W-1:0]  priOut,
  output logic              dropOut
);
  logic [7:0] regQ [N_SLOTS];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_reg
    if (i < N_REGS) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)                   regQ[i] <= '0;
        else if (strobe.wrByte[i]) regQ[i] <= wrData;
      end
    end else begin : g_hole
      assign regQ[i] = '0;
    end
  end

  assign rdData = regQ[rdAddr];

  // settings nibble {pri, drop} from a pair byte
  function automatic logic [PRI_W:0] slotOf(input logic [7:0] b, input logic odd);
    return odd ? b[7:4] : b[3:0];
  endfunction

  logic [N_USER-1:0]  userHit;
  logic [PRI_W:0]     userSet [N_USER];
  logic [N_WK-1:0]    wkHit;
  logic [PRI_W:0]     wkSet [N_WK];

  for (genvar i = 0; i < N_USER; i++) begin : g_user
    logic [PORT_W-1:0] val;
    assign val        = {regQ[A_USER_HI+i], regQ[A_USER_LO+i]};
    assign userHit[i] = regQ[A_USER_EN][i] && (srcPort == val || dstPort == val);
    assign userSet[i] = slotOf(regQ[A_USER_PRI + i/2], 1'(i % 2));
  end

  for (genvar k = 0; k < N_WK; k++) begin : g_wk
    logic [PORT_W-1:0] val;
    assign val      = WK_PORTS[k*PORT_W +: PORT_W];
    assign wkHit[k] = regQ[A_WK_EN][k] && (srcPort == val || dstPort == val);
    assign wkSet[k] = slotOf(regQ[A_WK_PRI + k/2], 1'(k % 2));
  end

  logic [PORT_W-1:0] rngLo, rngHi;
  logic              rngOn, rngHit;
  assign rngLo  = {regQ[A_RLO_H], regQ[A_RLO_L]};
  assign rngHi  = {regQ[A_RHI_H], regQ[A_RHI_L]};
  assign rngOn  = rngHi > rngLo;
  assign rngHit = rngOn && ((srcPort > rngLo && srcPort < rngHi) ||
                            (dstPort > rngLo && dstPort < rngHi));

  // lowest precedence assigned first, later assignments override
  logic           hitNext;
  logic [PRI_W:0] setNext;
  always_comb begin
    hitNext = 1'b0;
    setNext = '0;
    if (rngHit) begin
      hitNext = 1'b1;
      setNext = regQ[A_RNG_PRI][PRI_W:0];
    end
    for (int i = N_USER - 1; i >= 0; i--) begin
      if (userHit[i]) begin
        hitNext = 1'b1;
        setNext = userSet[i];
      end
    end
    for (int k = N_WK - 1; k >= 0; k--) begin
      if (wkHit[k]) begin
        hitNext = 1'b1;
        setNext = wkSet[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.classify || !hitNext) begin
      matchOut <= 1'b0;
      priOut   <= '0;
      dropOut  <= 1'b0;
    end else begin
      matchOut <= 1'b1;
      priOut   <= setNext[PRI_W:1];
      dropOut  <= setNext[0];
    end
  end
endmodule

// File: rtl/portPriClassifier.sv
module portPriClassifier
  import ppc_pkg::*;
#(
  parameter logic [N_WK*PORT_W-1:0] WK_PORTS = {16'd110, 16'd23, 16'd21, 16'd25,
                                                16'd22, 16'd53, 16'd443, 16'd80}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic              lookupValid,
  input  logic              isTcpUdp,
  input  logic [PORT_W-1:0] srcPort,
  input  logic [PORT_W-1:0] dstPort,
  output logic              matchOut,
  output logic [PRI_W-1:0]  priOut,
  output logic              dropOut
);
  ppcStrobe_t strobe;

  ppcCtrl uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .lookupValid(lookupValid),
    .isTcpUdp(isTcpUdp), .strobe(strobe)
  );

  ppcDatapath #(.WK_PORTS(WK_PORTS)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srcPort(srcPort), .dstPort(dstPort),
    .matchOut(matchOut), .priOut(priOut), .dropOut(dropOut)
  );
endmodule

// File: rtl/ppcChecker.sv
module ppcChecker
  import ppc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              lookupValid,
  input logic              isTcpUdp,
  input logic              matchOut,
  input logic [PRI_W-1:0]  priOut,
  input logic              dropOut
);
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!lookupValid || !isTcpUdp) |=> (!matchOut && priOut == '0 && !dropOut)); // R9

  AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    !matchOut |-> (priOut == '0 && !dropOut)); // R9

  AST_MATCH_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> $past(lookupValid && isTcpUdp)); // R10

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (wrEn && int'(wrAddr) < N_REGS && rdAddr == wrAddr)
      |=> (rdAddr != $past(rdAddr) || rdData == $past(wrData))); // R2

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (int'(rdAddr) >= N_REGS) |-> rdData == 8'h00); // R11
endmodule

bind portPriClassifier ppcChecker uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .lookupValid(lookupValid),
  .isTcpUdp(isTcpUdp), .matchOut(matchOut), .priOut(priOut), .dropOut(dropOut)
);

// File: tb/tb_portPriClassifier.sv
module tb_portPriClassifier;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] TB_WK = {16'd6000, 16'd110, 16'd23, 16'd21,
                                    16'd25, 16'd22, 16'd53, 16'd80};

  logic clk = 0, rst = 1;
  logic wrEn = 0, lookupValid = 0, isTcpUdp = 0;
  logic [4:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0, rdData;
  logic [15:0] srcPort = 0, dstPort = 0;
  logic matchOut, dropOut;
  logic [2:0] priOut;

  int checks = 0, failures = 0;
  string curReq = "R1";
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  portPriClassifier #(.WK_PORTS(TB_WK)) dut (.*);

  // behavioural reference model
  int mdl [32];
  bit expM; int expP; bit expD;

  function automatic int nib(int b, int idx);
    return (idx % 2) ? (b >> 4) & 15 : b & 15;
  endfunction

  function automatic void refLookup(int s, int d, output bit m, output int p, output bit dr);
    int sel; int lo, hi;
    m = 0; sel = 0;
    for (int k = 0; k < 8 && !m; k++) begin
      int wp = int'(TB_WK[k*16 +: 16]);
      if (mdl[21][k] && (s == wp || d == wp)) begin m = 1; sel = nib(mdl[22 + k/2], k); end
    end
    for (int i = 0; i < 8 && !m; i++) begin
      int up = mdl[8+i] * 256 + mdl[i];
      if (mdl[16][i] && (s == up || d == up)) begin m = 1; sel = nib(mdl[17 + i/2], i); end
    end
    lo = mdl[27] * 256 + mdl[26];
    hi = mdl[29] * 256 + mdl[28];
    if (!m && hi > lo && ((s > lo && s < hi) || (d > lo && d < hi))) begin
      m = 1; sel = mdl[30] & 15;
    end
    p = m ? (sel >> 1) : 0;
    dr = m ? sel[0] : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mdl[i]) mdl[i] = 0;
      expM = 0; expP = 0; expD = 0;
    end else begin
      if (lookupValid && isTcpUdp) refLookup(int'(srcPort), int'(dstPort), expM, expP, expD);
      else begin expM = 0; expP = 0; expD = 0; end
      if (wrEn && wrAddr < 31) mdl[wrAddr] = int'(wrData);
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      checks++;
      if (matchOut !== expM || int'(priOut) != expP || dropOut !== expD) begin
        failures++;
        $display("FAIL %s outputs act=%0b/%0d/%0b exp=%0b/%0d/%0b t=%0t",
                 curReq, matchOut, priOut, dropOut, expM, expP, expD, $time);
      end
      checks++;
      if (int'(rdData) != mdl[rdAddr]) begin
        failures++;
        $display("FAIL %s rdData[%0d] act=%0h exp=%0h", curReq, rdAddr, rdData, mdl[rdAddr]);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    wrEn = 1; wrAddr = 5'(a); wrData = 8'(d); step(); wrEn = 0;
  endtask

  task automatic wr16(int aLo, int aHi, int v);
    wr(aLo, v & 255); wr(aHi, v >> 8);
  endtask

  task automatic look(int s, int d, bit tcp = 1);
    lookupValid = 1; isTcpUdp = tcp; srcPort = 16'(s); dstPort = 16'(d);
    step(); lookupValid = 0; isTcpUdp = 0; step();
  endtask

  task automatic sweep();
    for (int a = 0; a < 32; a++) begin rdAddr = 5'(a); step(); end
    rdAddr = 0;
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    curReq = "R1"; sweep();
    curReq = "R2";
    for (int a = 0; a < 31; a++) wr(a, (a * 37 + 5) & 255);
    sweep();
    for (int a = 0; a < 31; a++) wr(a, 0);
    sweep();
    curReq = "R3";
    wr16(3, 11, 5000); wr16(2, 10, 6000);
    wr(18, 8'hB4);                 // entry3 pri5 drop1, entry2 pri2 drop0
    wr(16, 8'h0C);
    look(1234, 5000); look(6000, 1); look(6001, 4999);
    curReq = "R4";
    wr16(4, 12, 7000); wr(19, 8'hEE);
    look(7000, 7000);
    wr(16, 8'h04); look(1, 5000);
    curReq = "R5";
    wr(21, 8'h01); wr(22, 8'h02); look(80, 9); look(9, 80);
    wr(21, 8'h00); look(80, 80);
    curReq = "R8";
    wr(21, 8'h80); wr(25, 8'hE0);  // wk entry7 (6000) pri7
    look(6000, 80);
    wr16(0, 8, 9000); wr16(1, 9, 9000); wr(17, 8'h6A); wr(16, 8'h07);
    look(9000, 3);
    curReq = "R6";
    wr16(26, 27, 1000); wr16(28, 29, 2000); wr(30, 8'h07);
    look(1000, 2000); look(1001, 1); look(2, 1999); look(999, 2001);
    curReq = "R8";
    wr16(5, 13, 1500); wr(19, 8'h80); wr(16, 8'h27);
    look(1500, 1700); look(1700, 1);
    curReq = "R7";
    wr16(28, 29, 1000); look(1001, 999);
    wr16(28, 29, 999); look(1000, 998); look(1001, 1001);
    curReq = "R9";
    look(1500, 9000, 0); look(40000, 40001);
    lookupValid = 0; isTcpUdp = 1; srcPort = 1500; step(); step(); isTcpUdp = 0;
    curReq = "R10";
    wr16(6, 14, 16'h0100); wr(20, 8'h0C); wr(16, 8'h67);
    wrEn = 1; wrAddr = 6; wrData = 8'h01;
    lookupValid = 1; isTcpUdp = 1; srcPort = 16'h0101; dstPort = 0;
    step(); wrEn = 0;
    step(); lookupValid = 0; isTcpUdp = 0; step();
    curReq = "R11";
    wr(31, 8'hFF); sweep();
    repeat (2) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule